// File: doc/BRIEF.md
# Bit-Serial Add-Two Converter

This block takes a 4-bit unsigned operand one bit per clock, least significant bit first, and returns the bits of the operand plus two, truncated to four bits, in the same order. Each output bit appears combinationally in the same cycle as its input bit, as in a Mealy machine. On the fourth bit of each frame it also raises an overflow flag if the true sum does not fit in four bits.

A strobe marks the cycles that carry an operand bit. Cycles without the strobe are gaps. A gap does not advance the frame and does not disturb the carry. After the fourth valid bit the next valid bit starts a new frame, with no idle cycle needed. The only state the block holds is a 2-bit bit position and a single carry bit.

Top module: `serial_add2`

## Requirements
- R1: In a valid cycle at bit position 0 (the first bit of a frame, the operand's least significant bit), sum_o equals bit_i.
- R2: In a valid cycle at bit position 1, sum_o equals the inverse of bit_i.
- R3: Over the four valid bits of a frame, sum_o carries bit k of (N + 2) mod 16 in the cycle where bit_i carries bit k of N, for k = 0 to 3. For example, N = 14 gives 0000 and N = 15 gives 0001.
- R4: On the fourth valid bit of a frame (position 3), ovf_o is 1 exactly when N is 14 or 15.
- R5: ovf_o is 0 on bit positions 0, 1 and 2.
- R6: When bit_vld_i is 0, both sum_o and ovf_o are 0. The bit position and the carry are unchanged, so a frame split by gaps of any length gives the same results as an unbroken one.
- R7: The valid bit that follows a frame's fourth bit is bit 0 of a new frame, with the carry cleared. Back-to-back frames do not affect each other.
- R8: Asserting rst_ni low (asynchronous, active low) abandons any partial frame. The first valid bit after reset is bit 0 of a fresh frame with the carry cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | The current cycle carries an operand bit |
| bit_i | input | 1 | Serial operand bit, least significant bit first |
| sum_o | output | 1 | Serial bit of (N + 2) mod 16, valid in the same cycle |
| ovf_o | output | 1 | Overflow, only on the fourth bit of a frame |

## Verification
The assertions check on every cycle that both outputs are quiet during gaps and that the position and carry hold during gaps. They also check that the position advances by one on each valid bit, that the carry is zero at position 0, that overflow appears only at position 3, and that the sum bit follows or inverts the input bit at positions 0 and 1. Only the bench's scenarios can show that a whole frame produces the right sum and overflow for each operand value. The same holds for frames split by random gaps and for frames sent back to back. A reset in the middle of a frame must also leave the following frame correct, which again only a scenario can show.

// File: rtl/serial_add2_pkg.sv
package serial_add2_pkg;
  localparam int unsigned FRAME_BITS = 4;
  localparam int unsigned ADDEND     = 2;
  localparam int unsigned POS_W      = $clog2(FRAME_BITS);
  typedef logic [POS_W-1:0] pos_t;
endpackage

// File: rtl/sa_pos_counter.sv
module sa_pos_counter
  import serial_add2_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output pos_t pos_o,
  output logic last_o
);
  localparam pos_t LAST_POS = pos_t'(FRAME_BITS - 1);

  pos_t pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= '0;
    else if (adv_i) pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + pos_t'(1);
  end

  assign pos_o  = pos_q;
  assign last_o = (pos_q == LAST_POS);

  // R6
  hold_in_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(pos_q));

  // R7
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && pos_q != LAST_POS) |=> pos_q == $past(pos_q) + pos_t'(1));

  // R7
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && pos_q == LAST_POS) |=> pos_q == '0);
endmodule

// File: rtl/sa_const_adder.sv
module sa_const_adder
  import serial_add2_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic bit_i,
  input  pos_t pos_i,
  input  logic last_i,
  output logic sum_o,
  output logic cout_o
);
  localparam logic [FRAME_BITS-1:0] ADD_VEC = ADDEND[FRAME_BITS-1:0];

  logic carry_q;
  logic k_bit;

  assign k_bit  = ADD_VEC[pos_i];
  assign sum_o  = vld_i & (bit_i ^ k_bit ^ carry_q);
  assign cout_o = (bit_i & k_bit) | (carry_q & (bit_i ^ k_bit));

  // carry dropped at frame end so the next frame starts clean
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    carry_q <= 1'b0;
    else if (vld_i) carry_q <= last_i ? 1'b0 : cout_o;
  end

  // R7
  carry_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_i == '0) |-> !carry_q);

  // R6
  carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(carry_q));
endmodule

// File: rtl/serial_add2.sv
module serial_add2
  import serial_add2_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic sum_o,
  output logic ovf_o
);
  pos_t pos;
  logic last;
  logic cout;

  sa_pos_counter u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (bit_vld_i),
    .pos_o  (pos),
    .last_o (last)
  );

  sa_const_adder u_add (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (bit_vld_i),
    .bit_i  (bit_i),
    .pos_i  (pos),
    .last_i (last),
    .sum_o  (sum_o),
    .cout_o (cout)
  );

  assign ovf_o = bit_vld_i & last & cout;

  // R6
  gap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |-> (!sum_o && !ovf_o));

  // R5
  ovf_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (bit_vld_i && pos == pos_t'(FRAME_BITS - 1)));

  // R1
  bit0_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && pos == pos_t'(0)) |-> (sum_o == bit_i));

  // R2
  bit1_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && pos == pos_t'(1)) |-> (sum_o == !bit_i));
endmodule

// File: tb/serial_add2_tb_top.sv
module serial_add2_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic bit_in = 1'b0;
  logic sum, ovf;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  serial_add2 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_vld_i(vld), .bit_i(bit_in),
    .sum_o(sum), .ovf_o(ovf)
  );

  function automatic logic exp_sum(input int n, input int k);
    int s = (n + 2) % 16;
    return logic'((s >> k) & 1);
  endfunction

  function automatic logic exp_ovf(input int n, input int k);
    return logic'(k == 3 && n >= 14);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic gap(input int len);
    for (int g = 0; g < len; g++) begin
      @(negedge clk);
      vld = 1'b0;
      bit_in = logic'($urandom_range(0, 1));
      #1;
      check("R6 sum in gap", sum, 1'b0);
      check("R6 ovf in gap", ovf, 1'b0);
    end
  endtask

  task automatic send(input int n, input int max_gap, input string tag);
    for (int k = 0; k < 4; k++) begin
      if (max_gap > 0) gap($urandom_range(0, max_gap));
      @(negedge clk);
      vld = 1'b1;
      bit_in = logic'((n >> k) & 1);
      #1;
      if (k == 0)      check({tag, " R1 sum bit0"}, sum, exp_sum(n, k));
      else if (k == 1) check({tag, " R2 sum bit1"}, sum, exp_sum(n, k));
      else             check({tag, " R3 sum bit"}, sum, exp_sum(n, k));
      if (k == 3)      check({tag, " R4 ovf"}, ovf, exp_ovf(n, k));
      else             check({tag, " R5 ovf early"}, ovf, 1'b0);
    end
    @(negedge clk);
    vld = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5a17));
    #1;
    check("R8 sum in reset", sum, 1'b0);
    check("R8 ovf in reset", ovf, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // all operands, back to back
    for (int n = 0; n < 16; n++) send(n, 0, "dir");
    // R7: overflow frame followed directly by zero
    send(15, 0, "R7 a");
    send(0, 0, "R7 b");
    send(14, 0, "R7 c");
    send(3, 0, "R7 d");
    // R6: gapped frames
    for (int i = 0; i < 300; i++) send(int'($urandom_range(0, 15)), 3, "rnd");
    // R8: reset mid-frame
    @(negedge clk);
    vld = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    vld = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R8 sum during reset", sum, 1'b0);
    check("R8 ovf during reset", ovf, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    send(15, 0, "R8 post");
    send(14, 2, "R8 post2");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule